// File: doc/BRIEF.md
# Dual-CPU Interrupt Status and Mask Controller

This block gathers up to 64 level-type interrupt sources into one shared status vector and holds a separate enable mask for each of two processors. Each processor receives a single request line, raised when at least one source is both active in the shared status and enabled in that processor's own mask. Request 0 feeds core interrupt input 2 of processor 0 and request 1 feeds core interrupt input 3 of processor 1.

Software sees the status and both mask vectors as 32-bit words on a simple register bus. When the vectors are two words wide, the word carrying the upper sources sits at the lower address. A contiguous window of source positions can optionally be taken from a set of external interrupt lines rather than from the internal sources, so external pins share the same status and mask machinery.

Top module: `irq_dual_cpu_ctrl`

## Requirements
- R1: Every source bit is registered into the status vector on each clock; a level change on an input shows in the status one clock later, and that status can be read through either processor's status words.
- R2: Word address = cpu*(2*WORDS) + kind*WORDS + slot, with kind 0 for status and 1 for mask; source i lives in slot (i/32) XOR (WORDS-1) at bit i%32, so with 64 sources the word for sources 32..63 is slot 0. Read data appears on `reg_rdata` one clock after `reg_addr` is presented.
- R3: Each processor owns its own mask vector; a write to one processor's mask word leaves the other processor's mask unchanged, so one source can be enabled for one processor and disabled for the other.
- R4: `irq_req[c]` is the registered OR of (status AND mask of processor c); it rises one clock after both the status bit and the mask bit are set, including when they are set on the same clock.
- R5: With cascading enabled, source positions EXT_LO..EXT_HI (default 40..43) take their level from `ext_line[i-EXT_LO]`; the internal inputs at those positions have no effect.
- R6: Synchronous active-low reset clears status, both masks, both requests and the read data.
- R7: Status words are read-only; a write to a status address changes neither the status read back nor any mask.
- R8: Addresses at or above 4*WORDS are unimplemented: writes to them change no mask, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| int_src | input | NUM_SRC | Internal interrupt source levels, active high |
| ext_line | input | EXT_HI-EXT_LO+1 | External interrupt levels mapped into the cascade window |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address (4 bits with 64 sources) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous address |
| irq_req | output | 2 | Interrupt request per processor, bit 0 to processor 0 |

## Verification
The two functions that can land on the same clock are a mask write and a change in source level, both feeding the request path. The bench raises a source on the very edge at which the matching mask word is written, then requires the request to be low one clock later and high the clock after that, once for each processor. The sweeps also put a write to one processor's mask next to the other processor's live request, and judge that request unchanged.

// File: rtl/irq_dc_pkg.sv
// Package: shared constants, register kind encoding and slot arithmetic for
// the dual-CPU interrupt status/mask controller.
package irq_dc_pkg;

    localparam int WORD_W = 32;
    localparam int NUM_CPU = 2;

    typedef enum logic {
        KIND_STATUS = 1'b0,
        KIND_MASK   = 1'b1
    } reg_kind_e;

    // Lowest source index held in an address slot; high word at low slot.
    function automatic int slot_base(input int slot, input int words);
        return (slot ^ (words - 1)) * WORD_W;
    endfunction

endpackage

// File: rtl/irq_src_capture.sv
// Module: irq_src_capture
// Registers the source levels into the shared status vector. Positions in
// the cascade window are taken from the external lines when cascading is on.
// Assumes: EXT_LO <= EXT_HI < NUM_SRC; inputs are already synchronous.
module irq_src_capture #(
    parameter int NUM_SRC    = 64,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_LO     = 40,
    parameter int EXT_HI     = 43,
    localparam int EXT_N     = EXT_HI - EXT_LO + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] int_src,
    input  logic [EXT_N-1:0]   ext_line,
    output logic [NUM_SRC-1:0] status_q
);

    logic [NUM_SRC-1:0] level_sel;

    // Per-bit source selection between internal input and external line.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        if (CASCADE_EN && (i >= EXT_LO) && (i <= EXT_HI)) begin : g_ext
            logic unused_int_bit;
            assign unused_int_bit = int_src[i];
            assign level_sel[i]   = ext_line[i - EXT_LO];
        end else begin : g_int
            assign level_sel[i] = int_src[i];
        end
    end

    // Status register: sampled level of every source, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= level_sel;
    end

endmodule

// File: rtl/irq_addr_decode.sv
// Module: irq_addr_decode
// Splits a word address into processor, register kind and slot fields.
// Assumes: WORDS is a power of two; layout is cpu, then kind, then slot.
module irq_addr_decode
    import irq_dc_pkg::*;
#(
    parameter int WORDS  = 2,
    parameter int ADDR_W = 4,
    localparam int SLOT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              cpu_sel,
    output reg_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);

    localparam int IMPL = 4 * WORDS;

    // Field extraction by arithmetic on the word address.
    always_comb begin
        int a;
        a       = int'(addr);
        hit     = (a < IMPL);
        cpu_sel = ((a / (2 * WORDS)) % 2) == 1;
        kind    = (((a / WORDS) % 2) == 1) ? KIND_MASK : KIND_STATUS;
        slot    = SLOT_W'(a % WORDS);
    end

endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// One processor's mask vector and its registered request output.
// Assumes: wr_en is already qualified for this processor's mask words.
module irq_mask_bank
    import irq_dc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    localparam int WORDS  = NUM_SRC / WORD_W,
    localparam int SLOT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  slot,
    input  logic [WORD_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] status,
    output logic [NUM_SRC-1:0] mask_q,
    output logic               req_q
);

    // One 32-bit mask slice per address slot.
    for (genvar w = 0; w < WORDS; w++) begin : g_slot
        localparam int BASE = slot_base(w, WORDS);
        // Slice update on a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[BASE +: WORD_W] <= '0;
            else if (wr_en && (int'(slot) == w))
                mask_q[BASE +: WORD_W] <= wdata;
        end
    end

    // Request: any source both pending and enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |(status & mask_q);
    end

endmodule

// File: rtl/irq_dual_cpu_ctrl.sv
// Module: irq_dual_cpu_ctrl
// Top: shared status, two mask banks, register read mux and requests.
// Assumes: NUM_SRC is 32 or 64; register bus is single-cycle write,
// one-cycle-latency read with no handshake.
module irq_dual_cpu_ctrl
    import irq_dc_pkg::*;
#(
    parameter int NUM_SRC    = 64,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_LO     = 40,
    parameter int EXT_HI     = 43,
    localparam int EXT_N     = EXT_HI - EXT_LO + 1,
    localparam int WORDS     = NUM_SRC / WORD_W,
    localparam int ADDR_W    = $clog2(4 * WORDS) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] int_src,
    input  logic [EXT_N-1:0]   ext_line,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    output logic [NUM_CPU-1:0] irq_req
);

    localparam int SLOT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q [NUM_CPU];
    logic               dec_hit;
    logic               dec_cpu;
    reg_kind_e          dec_kind;
    logic [SLOT_W-1:0]  dec_slot;
    logic [NUM_CPU-1:0] bank_we;

    irq_src_capture #(
        .NUM_SRC   (NUM_SRC),
        .CASCADE_EN(CASCADE_EN),
        .EXT_LO    (EXT_LO),
        .EXT_HI    (EXT_HI)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .int_src (int_src),
        .ext_line(ext_line),
        .status_q(status_q)
    );

    irq_addr_decode #(
        .WORDS (WORDS),
        .ADDR_W(ADDR_W)
    ) u_decode (
        .addr   (reg_addr),
        .hit    (dec_hit),
        .cpu_sel(dec_cpu),
        .kind   (dec_kind),
        .slot   (dec_slot)
    );

    // One mask bank per processor, each with its own write qualifier.
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign bank_we[c] = reg_we && dec_hit && (dec_kind == KIND_MASK)
                            && (dec_cpu == c[0]);
        irq_mask_bank #(
            .NUM_SRC(NUM_SRC)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bank_we[c]),
            .slot  (dec_slot),
            .wdata (reg_wdata),
            .status(status_q),
            .mask_q(mask_q[c]),
            .req_q (irq_req[c])
        );
    end

    // Read mux: registered word from status or selected mask, zero if unmapped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (!dec_hit) begin
            reg_rdata <= '0;
        end else if (dec_kind == KIND_STATUS) begin
            reg_rdata <= status_q[slot_base(int'(dec_slot), WORDS) +: WORD_W];
        end else begin
            reg_rdata <= mask_q[dec_cpu][slot_base(int'(dec_slot), WORDS) +: WORD_W];
        end
    end

endmodule

// File: rtl/irq_dual_cpu_chk.sv
// Module: irq_dual_cpu_chk
// Property checker bound to irq_dual_cpu_ctrl; observes ports and state.
module irq_dual_cpu_chk #(
    parameter int NUM_SRC    = 64,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_LO     = 40,
    parameter int EXT_HI     = 43,
    parameter int ADDR_W     = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] int_src,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_rdata,
    input logic [1:0]         irq_req,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask0,
    input logic [NUM_SRC-1:0] mask1
);

    localparam int WORDS = NUM_SRC / 32;
    localparam int IMPL  = 4 * WORDS;

    function automatic logic [NUM_SRC-1:0] win_bits();
        logic [NUM_SRC-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_SRC; i++)
            if (CASCADE_EN && i >= EXT_LO && i <= EXT_HI) v[i] = 1'b1;
        return v;
    endfunction

    localparam logic [NUM_SRC-1:0] WIN = win_bits();

    p_status_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & ~WIN) == ($past(int_src) & ~WIN)));

    p_req0_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & mask0)) |=> irq_req[0]);
    p_req0_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_q & mask0)) |=> !irq_req[0]);
    p_req1_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_q & mask1)) |=> irq_req[1]);
    p_req1_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_q & mask1)) |=> !irq_req[1]);

    p_isolate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) < 2 * WORDS) |=> $stable(mask1));

    p_reset_r6: assert property (@(posedge clk)
        !rst_n |=> (irq_req == 2'b00 && mask0 == '0 && mask1 == '0));

    p_rsv_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_addr) >= IMPL) |=> (reg_rdata == 32'h0));
    p_rsv_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) >= IMPL) |=> ($stable(mask0) && $stable(mask1)));

endmodule

bind irq_dual_cpu_ctrl irq_dual_cpu_chk #(
    .NUM_SRC   (NUM_SRC),
    .CASCADE_EN(CASCADE_EN),
    .EXT_LO    (EXT_LO),
    .EXT_HI    (EXT_HI),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .int_src  (int_src),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .irq_req  (irq_req),
    .status_q (status_q),
    .mask0    (mask_q[0]),
    .mask1    (mask_q[1])
);

// File: tb/irq_dual_cpu_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dual_cpu_ctrl_bench;

    localparam int N    = 64;
    localparam int ELO  = 40;
    localparam int EHI  = 43;
    localparam int EN   = EHI - ELO + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  int_src = '0;
    logic [EN-1:0] ext_line = '0;
    logic          reg_we = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [1:0]    irq_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_dual_cpu_ctrl u_irq_dual_cpu_ctrl (
        .clk(clk), .rst_n(rst_n), .int_src(int_src), .ext_line(ext_line),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    function automatic logic [N-1:0] exp_status();
        logic [N-1:0] v;
        v = int_src;
        for (int k = 0; k < EN; k++) v[ELO + k] = ext_line[k];
        return v;
    endfunction

    function automatic logic [3:0] addr_of(int cpu, int kind, int slot);
        return 4'(cpu * 4 + kind * 2 + slot);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [N-1:0] es;
        repeat (3) @(negedge clk);
        // R6: reset state
        check("R6 irq_req", {30'b0, irq_req}, 32'h0);
        check("R6 rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), d);
            check("R6 regs zero", d, 32'h0);
        end

        // R1/R2/R5: one-hot sweep over internal and external inputs
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            int_src = '0; int_src[i] = 1'b1;
            ext_line = '0;
            if (i >= ELO && i <= EHI) ext_line[i - ELO] = 1'b1;
            @(negedge clk);
            es = exp_status();
            for (int c = 0; c < 2; c++)
                for (int s = 0; s < 2; s++) begin
                    rd(addr_of(c, 0, s), d);
                    check("R1 R2 R5 status word", d, es[(s ^ 1) * 32 +: 32]);
                end
            // R5: internal input alone inside window has no effect
            if (i >= ELO && i <= EHI) begin
                @(negedge clk);
                ext_line = '0;
                @(negedge clk);
                rd(addr_of(0, 0, 0), d);
                check("R5 window ignores int_src", d, 32'h0);
            end
        end

        // R3/R4: per-source, per-combination enable sweep
        for (int i = 0; i < N; i++) begin
            for (int combo = 0; combo < 4; combo++) begin
                int s;
                logic [31:0] bitv;
                s = (i / 32) ^ 1;
                bitv = 32'h1 << (i % 32);
                @(negedge clk);
                int_src = '0; ext_line = '0;
                if (i >= ELO && i <= EHI) ext_line[i - ELO] = 1'b1;
                else int_src[i] = 1'b1;
                wr(addr_of(0, 1, s), combo[0] ? bitv : 32'h0);
                wr(addr_of(1, 1, s), combo[1] ? bitv : 32'h0);
                @(negedge clk);
                check("R4 request per cpu", {30'b0, irq_req}, 32'(combo));
                rd(addr_of(0, 1, s), d);
                check("R3 mask cpu0", d, combo[0] ? bitv : 32'h0);
                rd(addr_of(1, 1, s), d);
                check("R3 mask cpu1", d, combo[1] ? bitv : 32'h0);
                rd(addr_of(0, 1, s ^ 1), d);
                check("R2 other slot untouched", d, 32'h0);
                wr(addr_of(0, 1, s), 32'h0);
                wr(addr_of(1, 1, s), 32'h0);
            end
        end

        // R4: mask write and source rise on the same edge, each cpu
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            int_src = '0; ext_line = '0;
            @(negedge clk);
            int_src[5] = 1'b1;
            reg_we = 1'b1; reg_addr = addr_of(c, 1, 1); reg_wdata = 32'h20;
            @(negedge clk);
            reg_we = 1'b0;
            check("R4 same-edge not yet", {30'b0, irq_req}, 32'h0);
            @(negedge clk);
            check("R4 same-edge raised", {30'b0, irq_req}, 32'(1 << c));
            wr(addr_of(c, 1, 1), 32'h0);
        end

        // R7: status is read-only
        @(negedge clk);
        int_src = '0; int_src[3] = 1'b1; int_src[63] = 1'b1; ext_line = '0;
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 2; s++) wr(addr_of(c, 0, s), 32'hFFFF_FFFF);
        rd(addr_of(0, 0, 1), d);
        check("R7 status low word", d, 32'h8);
        rd(addr_of(1, 0, 0), d);
        check("R7 status high word", d, 32'h8000_0000);
        for (int a = 0; a < 4; a++) begin
            rd(addr_of(a / 2, 1, a % 2), d);
            check("R7 masks untouched", d, 32'h0);
        end
        check("R7 no request", {30'b0, irq_req}, 32'h0);

        // R8: unimplemented addresses
        for (int a = 8; a < 16; a++) wr(4'(a), 32'hFFFF_FFFF);
        for (int a = 8; a < 16; a++) begin
            rd(4'(a), d);
            check("R8 read zero", d, 32'h0);
        end
        for (int a = 0; a < 4; a++) begin
            rd(addr_of(a / 2, 1, a % 2), d);
            check("R8 masks untouched", d, 32'h0);
        end
        check("R8 no request", {30'b0, irq_req}, 32'h0);

        // R6: reset mid-run clears masks and requests
        wr(addr_of(0, 1, 1), 32'h8);
        wr(addr_of(1, 1, 0), 32'h8000_0000);
        @(negedge clk);
        check("R6 pre-reset requests", {30'b0, irq_req}, 32'h3);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 requests cleared", {30'b0, irq_req}, 32'h0);
        rst_n = 1'b1;
        rd(addr_of(0, 1, 1), d);
        check("R6 mask cleared", d, 32'h0);
        @(negedge clk);
        @(negedge clk);
        check("R6 stays low", {30'b0, irq_req}, 32'h0);

        finish_run();
    end

endmodule